// File: doc/BRIEF.md
# Replayable Queue Buffer

This block is a single-clock first-in first-out store of 4096 words of 9 bits each. Producers present a word with a write strobe, consumers take words with a read strobe, and no address is ever supplied from outside. Occupancy is reported through three status outputs: empty, more-than-half-occupied and full. A registered output word carries a one-cycle valid pulse for each completed read.

The read side can be rewound. A rewind strobe moves the read position back to physical location zero and leaves the write position alone. The block written since reset can then be delivered again, as many times as needed, provided the write position never wraps.

Strobes act on their rising level. Each new assertion of an enable requests one operation. If the buffer cannot serve that request yet, because a read meets an empty buffer or a write meets a full one, the request waits as long as the enable stays high. It completes on the first cycle it is able to. This gives flow-through in both directions.

Top module: `qbuf_rtx`

## Requirements
- R1: A synchronous active-low reset makes empty 1, full 0, half_full 0, rd_valid 0 and rd_data 0. Words written before the reset can no longer be read out: a read strobe right after reset produces no rd_valid.
- R2: Reads return words in write order. rd_valid is 1 exactly in the cycle after the clock edge that accepted a read, with that word on rd_data. rd_data keeps its value when no read completes.
- R3: An operation is requested only when wr_en or rd_en is 1 in a cycle after a cycle in which it was 0. Holding the enable high requests nothing further.
- R4: A write requested while full, whose enable drops before space appears, stores nothing and leaves full at 1.
- R5: A read requested while empty, whose enable drops before data arrives, gives no rd_valid and leaves empty at 1.
- R6: empty is 1 exactly at 0 stored words. half_full is 1 exactly for DEPTH/2+1 up to DEPTH words. full is 1 exactly at DEPTH words. Occupancy never exceeds DEPTH.
- R7: When neither full nor empty, a read and a write accepted on the same edge both take effect and leave occupancy unchanged.
- R8: A rewind (rtx high with rd_en and wr_en low) sets the read position to location zero and sets occupancy to the number of words written since reset. The next read returns the first word written, and this can be repeated.
- R9: rtx is ignored in any cycle in which rd_en or wr_en is 1.
- R10: A read held while empty completes on the edge after the edge that stores the next word. empty is 0 for exactly one cycle in between. Further writes while the read stays held are not delivered.
- R11: A write held while full is stored on the edge after the edge that accepts a read. full is 0 for exactly one cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, active high |
| wr_data | input | WIDTH | Word to store, sampled when the write completes |
| rd_en | input | 1 | Read strobe, active high |
| rtx | input | 1 | Rewind the read position to location zero |
| rd_data | output | WIDTH | Last word read |
| rd_valid | output | 1 | One-cycle pulse after a completed read |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |
| empty | output | 1 | No word stored |

## Verification
Isolated pulses, held strobes and simultaneous read-write pairs are used to distinguish single-operation-per-strobe behaviour from repeated operations. A complete fill of 4096 words checks the half-full boundary between 2048 and 2049 words and the full boundary, and shows that a dropped write against a full buffer leaves no trace in the drained data. Rewinds are issued alone and together with a read enable, to separate an honoured replay from an ignored one. Held reads into an empty buffer and held writes into a full buffer check the one-cycle flag dips of flow-through and that only the first word flows.

// File: rtl/qbuf_pkg.sv
// Package qbuf_pkg
// Shared defaults and the per-cycle operation bundle used by the queue buffer.
// Assumes nothing beyond a single clock domain.
package qbuf_pkg;

    localparam int QB_DEPTH = 4096;
    localparam int QB_WIDTH = 9;

    // Operations that complete on the current clock edge
    typedef struct packed {
        logic wr_go;
        logic rd_go;
        logic rtx_go;
    } qb_ops_t;

endpackage

// File: rtl/qb_strobe.sv
// Module qb_strobe
// Turns a level enable into at most one completed operation per assertion.
// A request arms when req rises. If allow is low it stays pending while req
// stays high, and it completes on the first cycle allow is high.
// Assumes req is synchronous to clk.
module qb_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic allow,
    output logic go
);

    logic prev_q;
    logic pend_q;
    logic armed;

    // Purpose: a request is live on a fresh rise or while still pending
    always_comb begin
        armed = req & (~prev_q | pend_q);
        go    = armed & allow;
    end

    // Purpose: remember last enable level and whether a request waits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req;
            pend_q <= armed & ~allow;
        end
    end

    // R3
    one_op_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    // R3
    pend_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !allow) |=> (pend_q && $past(req)));

endmodule

// File: rtl/qb_track.sv
// Module qb_track
// Holds the write position, the read position and the occupancy count.
// A rewind clears the read position and loads occupancy from the write
// position. Assumes the write position does not wrap during replay, and
// that a rewind never coincides with a read or a write.
module qb_track
    import qbuf_pkg::*;
#(
    parameter int DEPTH = QB_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  qb_ops_t                      ops,
    output logic [$clog2(DEPTH)-1:0]     wr_addr,
    output logic [$clog2(DEPTH)-1:0]     rd_addr,
    output logic [$clog2(DEPTH):0]       occ
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W-1:0] occ_q;

    // Purpose: advance positions and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (ops.wr_go) begin
                wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            end
            if (ops.rtx_go) begin
                rd_ptr_q <= '0;
            end else if (ops.rd_go) begin
                rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            end
            if (ops.rtx_go) begin
                occ_q <= wr_ptr_q;
            end else begin
                case ({ops.wr_go, ops.rd_go})
                    2'b10:   occ_q <= occ_q + PTR_W'(1);
                    2'b01:   occ_q <= occ_q - PTR_W'(1);
                    default: occ_q <= occ_q;
                endcase
            end
        end
    end

    // Purpose: expose memory addresses and occupancy
    always_comb begin
        wr_addr = wr_ptr_q[ADDR_W-1:0];
        rd_addr = rd_ptr_q[ADDR_W-1:0];
        occ     = occ_q;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL_LVL);

    // R8
    rtx_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ops.rtx_go |=> ((rd_ptr_q == '0) && (occ_q == $past(wr_ptr_q))));

    // R7
    rw_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ops.wr_go && ops.rd_go) |=> (occ_q == $past(occ_q)));

endmodule

// File: rtl/qb_flags.sv
// Module qb_flags
// Decodes occupancy into empty, more-than-half and full indications.
// Assumes occupancy never exceeds DEPTH.
module qb_flags #(
    parameter int DEPTH = 4096
) (
    input  logic [$clog2(DEPTH):0] occ,
    output logic                   empty,
    output logic                   half_full,
    output logic                   full
);

    localparam int PTR_W = $clog2(DEPTH) + 1;
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_LVL = PTR_W'(DEPTH / 2);

    // Purpose: compare occupancy against fixed thresholds
    always_comb begin
        empty     = (occ == '0);
        half_full = (occ > HALF_LVL);
        full      = (occ == FULL_LVL);
    end

endmodule

// File: rtl/qb_store.sv
// Module qb_store
// Word storage with one write port and one registered read port.
// The read register keeps its value unless a read completes; the valid
// pulse follows each completed read by one cycle. Storage is not cleared.
module qb_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_go,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     rd_valid
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Purpose: store an accepted word
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Purpose: register the word taken by a completed read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) begin
                rd_data <= mem_q[rd_addr];
            end
        end
    end

    // R2
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rd_valid);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

endmodule

// File: rtl/qbuf_rtx.sv
// Module qbuf_rtx
// Queue buffer top: two strobe trackers, position and occupancy tracking,
// flag decode and word storage. A rewind is honoured only when neither
// enable is high. Assumes all inputs are synchronous to clk.
module qbuf_rtx
    import qbuf_pkg::*;
#(
    parameter int DEPTH = QB_DEPTH,
    parameter int WIDTH = QB_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rtx,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             full,
    output logic             half_full,
    output logic             empty
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic              wr_go;
    logic              rd_go;
    logic              rtx_go;
    qb_ops_t           ops;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [PTR_W-1:0]  occ;
    logic              wr_allow;
    logic              rd_allow;

    // Purpose: gate requests by flags and qualify the rewind
    always_comb begin
        wr_allow = ~full;
        rd_allow = ~empty;
        rtx_go   = rtx & ~rd_en & ~wr_en;
        ops      = '{wr_go: wr_go, rd_go: rd_go, rtx_go: rtx_go};
    end

    qb_strobe u_wr_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (wr_en),
        .allow (wr_allow),
        .go    (wr_go)
    );

    qb_strobe u_rd_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rd_en),
        .allow (rd_allow),
        .go    (rd_go)
    );

    qb_track #(
        .DEPTH (DEPTH)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .ops     (ops),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .occ     (occ)
    );

    qb_flags #(
        .DEPTH (DEPTH)
    ) u_flags (
        .occ       (occ),
        .empty     (empty),
        .half_full (half_full),
        .full      (full)
    );

    qb_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_go    (rd_go),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R4
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_go);

    // R5
    no_read_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_go);

    // R9
    rtx_blocked_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtx && rd_go) |=> !empty || $past(occ) == PTR_W'(1));

endmodule

// File: tb/tb_qbuf_rtx.sv
`timescale 1ns/1ps
module tb_qbuf_rtx;

    localparam int DEPTH = 4096;
    localparam int WIDTH = 9;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [WIDTH-1:0] wr_data;
    logic             rd_en;
    logic             rtx;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid;
    logic             full;
    logic             half_full;
    logic             empty;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    qbuf_rtx #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rtx(rtx), .rd_data(rd_data), .rd_valid(rd_valid),
        .full(full), .half_full(half_full), .empty(empty)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] pat(input int k);
        return WIDTH'((k * 37 + 5) % 512);
    endfunction

    // Behavioural reference model, updated on every rising edge
    logic [WIDTH-1:0] m_hist [DEPTH];
    int   m_cnt = 0, m_wr = 0, m_rd = 0;
    bit   m_rprev = 0, m_rpend = 0, m_wprev = 0, m_wpend = 0;
    bit   m_valid = 0, m_live = 0;
    logic [WIDTH-1:0] m_data = '0;

    always @(posedge clk) begin
        bit r_arm, r_ok, w_arm, w_ok;
        if (!rst_n) begin
            m_cnt = 0; m_wr = 0; m_rd = 0;
            m_rprev = 0; m_rpend = 0; m_wprev = 0; m_wpend = 0;
            m_valid = 0; m_data = '0; m_live = 1;
        end else begin
            r_arm = rd_en && (!m_rprev || m_rpend);
            r_ok  = r_arm && (m_cnt > 0);
            w_arm = wr_en && (!m_wprev || m_wpend);
            w_ok  = w_arm && (m_cnt < DEPTH);
            m_valid = r_ok;
            if (r_ok) begin
                m_data = m_hist[m_rd % DEPTH];
                m_rd++;
                m_cnt--;
            end
            if (w_ok) begin
                m_hist[m_wr % DEPTH] = wr_data;
                m_wr++;
                m_cnt++;
            end
            if (rtx && !rd_en && !wr_en) begin
                m_rd  = 0;
                m_cnt = m_wr;
            end
            m_rpend = r_arm && !r_ok;
            m_wpend = w_arm && !w_ok;
            m_rprev = rd_en;
            m_wprev = wr_en;
        end
    end

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (m_live) begin
            check("R6 empty vs model", int'(empty), int'(m_cnt == 0));
            check("R6 full vs model", int'(full), int'(m_cnt == DEPTH));
            check("R6 half_full vs model", int'(half_full), int'(m_cnt > DEPTH / 2));
            check("R2 rd_valid vs model", int'(rd_valid), int'(m_valid));
            check("R2 rd_data vs model", int'(rd_data), int'(m_data));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rtx = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_pulse(input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse(output logic v, output logic [WIDTH-1:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        v = rd_valid; d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic fill_all(input bit with_checks);
        for (int k = 0; k < DEPTH; k++) begin
            wr_pulse(pat(k));
            if (with_checks) begin
                if (k == DEPTH / 2 - 1) check("R6 half_full low at DEPTH/2 words", int'(half_full), 0);
                if (k == DEPTH / 2)     check("R6 half_full high at DEPTH/2+1 words", int'(half_full), 1);
                if (k == DEPTH - 2)     check("R6 full low one below capacity", int'(full), 0);
                if (k == DEPTH - 1)     check("R6 full high at capacity", int'(full), 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=200000 cycles expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic v;
        logic [WIDTH-1:0] d;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rtx = 1'b0; wr_data = '0;
        do_reset();
        @(negedge clk);
        check("R1 empty after reset", int'(empty), 1);
        check("R1 full after reset", int'(full), 0);
        check("R1 half_full after reset", int'(half_full), 0);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        check("R1 rd_data after reset", int'(rd_data), 0);

        // R5: read pulse on empty buffer
        rd_pulse(v, d);
        check("R5 no valid from empty read", int'(v), 0);
        check("R5 still empty", int'(empty), 1);

        // R3: held write produces one word
        wr_pulse(9'h010); wr_pulse(9'h020); wr_pulse(9'h030);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 9'h040;
        repeat (4) @(negedge clk);
        wr_en = 1'b0;
        rd_pulse(v, d); check("R2 first word order", int'(d), 'h010);
        rd_pulse(v, d); check("R2 second word order", int'(d), 'h020);
        rd_pulse(v, d); check("R2 third word order", int'(d), 'h030);
        rd_pulse(v, d); check("R3 held write stored once", int'(d), 'h040);
        rd_pulse(v, d); check("R3 no extra word from held write", int'(v), 0);

        // R7: simultaneous read and write
        wr_pulse(9'h011); wr_pulse(9'h022);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 9'h033;
        @(negedge clk);
        check("R7 read side completed", int'(rd_valid), 1);
        check("R7 read data", int'(rd_data), 'h011);
        wr_en = 1'b0; rd_en = 1'b0;
        rd_pulse(v, d); check("R7 next word", int'(d), 'h022);
        rd_pulse(v, d); check("R7 written word kept", int'(d), 'h033);
        check("R7 occupancy back to zero", int'(empty), 1);

        // R6, R4, R8, R9 on a full buffer
        do_reset();
        fill_all(1'b1);
        wr_pulse(9'h1FF);
        check("R4 full unchanged after dropped write", int'(full), 1);
        for (int k = 0; k < 3; k++) begin
            rd_pulse(v, d); check("R2 read before rewind", int'(d), int'(pat(k)));
        end
        @(negedge clk); rtx = 1'b1;
        @(negedge clk); rtx = 1'b0;
        check("R8 occupancy restored to full", int'(full), 1);
        rd_pulse(v, d); check("R8 replay starts at first word", int'(d), int'(pat(0)));
        @(negedge clk); rtx = 1'b1;
        @(negedge clk); rtx = 1'b0;
        rd_pulse(v, d); check("R8 second replay starts at first word", int'(d), int'(pat(0)));
        @(negedge clk); rtx = 1'b1; rd_en = 1'b1;
        @(negedge clk); rtx = 1'b0; rd_en = 1'b0;
        check("R9 read with rtx returns next word", int'(rd_data), int'(pat(1)));
        rd_pulse(v, d); check("R9 rewind ignored while reading", int'(d), int'(pat(2)));
        for (int k = 3; k < DEPTH; k++) begin
            rd_pulse(v, d);
            if (d !== pat(k)) check("R2 drain order", int'(d), int'(pat(k)));
        end
        check("R4 last drained word", int'(d), int'(pat(DEPTH - 1)));
        rd_pulse(v, d); check("R4 dropped write never stored", int'(v), 0);

        // R11: write flow-through
        do_reset();
        fill_all(1'b0);
        @(negedge clk); wr_en = 1'b1; wr_data = 9'h155;
        repeat (3) @(negedge clk);
        check("R11 held write waits while full", int'(full), 1);
        rd_en = 1'b1;
        @(negedge clk);
        check("R11 full dips for one cycle", int'(full), 0);
        check("R11 read completed", int'(rd_data), int'(pat(0)));
        rd_en = 1'b0;
        @(negedge clk);
        check("R11 full reasserts", int'(full), 1);
        wr_en = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            rd_pulse(v, d);
            if (d !== pat(k)) check("R2 drain order after flow", int'(d), int'(pat(k)));
        end
        rd_pulse(v, d); check("R11 held word stored last", int'(d), 'h155);
        check("R11 empty after drain", int'(empty), 1);

        // R1: contents lost over reset
        wr_pulse(9'h0AA);
        do_reset();
        rd_pulse(v, d); check("R1 old contents unreadable", int'(v), 0);

        // R10: read flow-through
        @(negedge clk); rd_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 held read waits while empty", int'(rd_valid), 0);
        wr_en = 1'b1; wr_data = 9'h0C3;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 empty dips for one cycle", int'(empty), 0);
        check("R10 not yet delivered", int'(rd_valid), 0);
        @(negedge clk);
        check("R10 word flows through", int'(rd_valid), 1);
        check("R10 flowed data", int'(rd_data), 'h0C3);
        check("R10 empty again", int'(empty), 1);
        wr_pulse(9'h0D4);
        check("R10 second word not delivered", int'(rd_valid), 0);
        @(negedge clk);
        check("R10 second word stays stored", int'(empty), 0);
        rd_en = 1'b0;
        rd_pulse(v, d); check("R10 fresh strobe fetches second word", int'(d), 'h0D4);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule